// File: doc/BRIEF.md
# USB 2.0 PHY Bring-Up Sequencer with Shared Use Count

This block is a hardware state machine that powers up a USB 2.0 PHY through a small register write port and later powers it down again. Several clients share the PHY. Each client raises an init or shutdown request and holds it until the block acknowledges it. The block keeps a use count. Only the first init that arrives while the count is zero runs the power-up sequence, and only the shutdown that brings the count from one to zero switches the PHY off.

The power-up sequence has a fixed order. The block enables the PHY, then starts its PLL, and then writes the optional tuning registers. Next it polls the PHY status word with a bounded number of timed retries. When the PHY reports ready, the block releases the PHY from reset, writes the board port configuration word and clears the two bus-alignment registers. If the PHY never reports ready, the block stops before the reset release and raises an error.

The block produces each register write as a single-cycle strobe on a bank, address and data bus. The receiving register file decodes the addresses listed in the requirements. The PHY status word arrives on a plain input and passes through a two-flop synchronizer.

Top module: `phy_bringup_seq`

## Requirements
- R1: After reset the block is idle. `busy`, `done`, `error` and `underflow` are 0, `use_count` is 0, no write strobe is issued and no acknowledge is given.
- R2: Requests are accepted only while the block is idle. An accepted request is answered by a one-cycle `init_ack` or `shut_ack`. Init wins when both requests are present. `busy` is high from the cycle after a power-up start until the sequence ends. A request that arrives while the block is busy stays unacknowledged until the block is idle again.
- R3: The first init writes control offset 0x04 in bank 0 three times, in this order: 0x1 (enable), then 0x3 (enable and PLL), then 0x7 (enable, PLL and reset release). The 0x7 write comes after the status poll succeeds. Bit 0 is enable, bit 1 is PLL enable and bit 2 is reset release.
- R4: When `tune_present` is 1, the block writes bank 1 offset 0x24 and then offset 0x28, between the 0x3 write and the poll. The values are 0x41 and 0x0D when `bead_tune` is 1, and 0x00 and 0x07 when it is 0. When `tune_present` is 0, the block skips both writes.
- R5: The PHY counts as ready only when the synchronized status word equals 0xC000_0000 (bits 31 and 30 set, all other bits clear). Each status sample is taken after a wait of `WAIT_US` microseconds, counted in clock cycles derived from `CLK_KHZ`.
- R6: If `MAX_POLLS` samples all fail, the block sets `error`, pulses `done` and returns to idle. The 0x7 reset-release write does not happen, and no port or alignment write follows.
- R7: The port word is written to bank 0 offset 0x00. Its bit 0 is `port1_func` and bit 4 is `pen_level`. Bits 8, 9 and 10 are `ovc_pin_sel[0..2]`. The active-high bits for ports 0, 1 and 2 sit at bits 3, 1 and 6. All other bits are 0.
- R8: After the port word, the block writes 0 to bank 0 offset 0x0C and then 0 to bank 0 offset 0x1C, in that order.
- R9: An init always increments `use_count`. An init that finds the count non-zero issues no write and pulses `done` in the cycle after its acknowledge.
- R10: A shutdown with a non-zero count decrements `use_count`. The block writes 0 to bank 0 offset 0x04 only when the count was one.
- R11: A shutdown that finds `use_count` at zero is acknowledged but leaves the count at zero and issues no write. It also sets `underflow`, which stays set until reset.
- R12: `done` is a one-cycle pulse at the end of every init. `error` is cleared when a new power-up sequence starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_req | input | 1 | Init request, held until `init_ack` |
| shut_req | input | 1 | Shutdown request, held until `shut_ack` |
| tune_present | input | 1 | Tuning register bank exists |
| bead_tune | input | 1 | Selects the ferrite-bead tuning values |
| port1_func | input | 1 | Port 1 runs in function mode |
| pen_level | input | 1 | Level of the port power-enable output |
| ovc_pin_sel | input | 3 | Over-current pin select, one bit per port |
| ovc_active_high | input | 3 | Over-current polarity, one bit per port |
| phy_status | input | 32 | Asynchronous PHY status word |
| init_ack | output | 1 | Init request taken |
| shut_ack | output | 1 | Shutdown request taken |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at the end of an init |
| error | output | 1 | Last power-up timed out |
| underflow | output | 1 | Sticky: shutdown arrived with zero count |
| use_count | output | CNT_W | Number of active users |
| reg_wr | output | 1 | Register write strobe |
| reg_bank | output | 1 | 0 = main bank, 1 = tuning bank |
| reg_addr | output | 8 | Register byte offset |
| reg_wdata | output | 32 | Register write data |

## Verification
The bench goes after the status compare. It uses a word that has both ready bits set plus one stray low bit. A design that tested only bits 31 and 30 would release reset on this word instead of timing out after the full poll budget. The bench also places each polarity bit on its own. A design that shifted these bits like the pin-select bits would put port 1 and port 2 at the wrong positions.

For the use count, the bench checks that a second init and a middle shutdown produce no writes at all. A design that gated on the new count instead of the old one would re-run the sequence or switch the PHY off too early. It also issues a shutdown at zero. A design without the underflow guard would wrap the count and could later power the PHY down while clients still hold it.

Finally, the bench holds a shutdown request during a power-up and checks that it is not acknowledged until the sequence has finished.

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq #(
  parameter int CLK_KHZ   = 200000,
  parameter int WAIT_US   = 10,
  parameter int MAX_POLLS = 1024,
  parameter int CNT_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_req,
  input  logic             shut_req,
  input  logic             tune_present,
  input  logic             bead_tune,
  input  logic             port1_func,
  input  logic             pen_level,
  input  logic [2:0]       ovc_pin_sel,
  input  logic [2:0]       ovc_active_high,
  input  logic [31:0]      phy_status,
  output logic             init_ack,
  output logic             shut_ack,
  output logic             busy,
  output logic             done,
  output logic             error,
  output logic             underflow,
  output logic [CNT_W-1:0] use_count,
  output logic             reg_wr,
  output logic             reg_bank,
  output logic [7:0]       reg_addr,
  output logic [31:0]      reg_wdata
);
  localparam int WAIT_CYC = (CLK_KHZ * WAIT_US + 999) / 1000 < 1 ? 1 : (CLK_KHZ * WAIT_US + 999) / 1000;
  localparam int WAIT_W   = $clog2(WAIT_CYC + 1);
  localparam int POLL_W   = $clog2(MAX_POLLS + 1);
  localparam int POL_POS [3] = '{3, 1, 6};
  localparam logic [31:0] READY_WORD = 32'hC000_0000;

  typedef enum logic [3:0] {
    S_IDLE, S_EN, S_PLL, S_TUN1, S_TUN2, S_WAIT, S_CHECK,
    S_RELEASE, S_PORT, S_EHCI, S_OHCI, S_OFF
  } state_t;

  state_t              state;
  logic [WAIT_W-1:0]   wait_cnt;
  logic [POLL_W-1:0]   polls;
  logic [31:0]         stat_m, stat_s;
  logic                ready;
  logic [31:0]         port_word;

  assign busy     = (state != S_IDLE);
  assign init_ack = !busy && init_req;
  assign shut_ack = !busy && shut_req && !init_req;
  assign ready    = (stat_s == READY_WORD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_m <= '0;
      stat_s <= '0;
    end else begin
      stat_m <= phy_status;
      stat_s <= stat_m;
    end
  end

  always_comb begin
    port_word    = '0;
    port_word[0] = port1_func;
    port_word[4] = pen_level;
    for (int i = 0; i < 3; i++) begin
      port_word[8 + i]       = ovc_pin_sel[i];
      port_word[POL_POS[i]]  = ovc_active_high[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      use_count <= '0;
      wait_cnt  <= '0;
      polls     <= '0;
      done      <= 1'b0;
      error     <= 1'b0;
      underflow <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (init_ack) begin
            use_count <= use_count + 1'b1;
            if (use_count == '0) begin
              state <= S_EN;
              error <= 1'b0;
            end else begin
              done <= 1'b1;
            end
          end else if (shut_ack) begin
            if (use_count == '0) begin
              underflow <= 1'b1;
            end else begin
              use_count <= use_count - 1'b1;
              if (use_count == CNT_W'(1)) state <= S_OFF;
            end
          end
        end
        S_EN:  state <= S_PLL;
        S_PLL: begin
          polls    <= '0;
          wait_cnt <= WAIT_W'(WAIT_CYC - 1);
          state    <= tune_present ? S_TUN1 : S_WAIT;
        end
        S_TUN1: state <= S_TUN2;
        S_TUN2: state <= S_WAIT;
        S_WAIT: begin
          if (wait_cnt == '0) state <= S_CHECK;
          else wait_cnt <= wait_cnt - 1'b1;
        end
        S_CHECK: begin
          if (ready) begin
            state <= S_RELEASE;
          end else if (polls == POLL_W'(MAX_POLLS - 1)) begin
            error <= 1'b1;
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            polls    <= polls + 1'b1;
            wait_cnt <= WAIT_W'(WAIT_CYC - 1);
            state    <= S_WAIT;
          end
        end
        S_RELEASE: state <= S_PORT;
        S_PORT:    state <= S_EHCI;
        S_EHCI:    state <= S_OHCI;
        S_OHCI: begin
          done  <= 1'b1;
          state <= S_IDLE;
        end
        S_OFF:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    reg_wr    = 1'b1;
    reg_bank  = 1'b0;
    reg_addr  = 8'h04;
    reg_wdata = 32'h0;
    case (state)
      S_EN:      reg_wdata = 32'h1;
      S_PLL:     reg_wdata = 32'h3;
      S_TUN1: begin
        reg_bank  = 1'b1;
        reg_addr  = 8'h24;
        reg_wdata = bead_tune ? 32'h41 : 32'h00;
      end
      S_TUN2: begin
        reg_bank  = 1'b1;
        reg_addr  = 8'h28;
        reg_wdata = bead_tune ? 32'h0D : 32'h07;
      end
      S_RELEASE: reg_wdata = 32'h7;
      S_PORT: begin
        reg_addr  = 8'h00;
        reg_wdata = port_word;
      end
      S_EHCI:    reg_addr = 8'h0C;
      S_OHCI:    reg_addr = 8'h1C;
      S_OFF:     reg_wdata = 32'h0;
      default:   reg_wr = 1'b0;
    endcase
  end

  assert_ack_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({init_ack, shut_ack}));

  assert_write_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> busy);

  assert_release_after_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_bank && reg_addr == 8'h04 && reg_wdata == 32'h7) |-> $past(ready));

  assert_no_release_on_error_R6: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !(reg_wr && reg_wdata == 32'h7));

  assert_init_counts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    init_ack |=> use_count == CNT_W'($past(use_count) + 1'b1));

  assert_underflow_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (shut_ack && use_count == '0) |=> (underflow && use_count == '0));

  assert_underflow_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/sim_phy_bringup_seq.sv
`timescale 1ns/1ps
module sim_phy_bringup_seq;
  localparam int CNT_W = 4;
  localparam int WAITC = 10;
  localparam int POLLS = 1024;

  logic clk = 0, rst_n = 0;
  logic init_req = 0, shut_req = 0;
  logic tune_present = 0, bead_tune = 0, port1_func = 0, pen_level = 0;
  logic [2:0] ovc_pin_sel = 0, ovc_active_high = 0;
  logic [31:0] phy_status = 32'hC000_0000;
  logic init_ack, shut_ack, busy, done, error, underflow;
  logic [CNT_W-1:0] use_count;
  logic reg_wr, reg_bank;
  logic [7:0] reg_addr;
  logic [31:0] reg_wdata;

  always #2.5 clk = ~clk;

  phy_bringup_seq #(.CLK_KHZ(1000), .WAIT_US(10), .MAX_POLLS(POLLS), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .init_req(init_req), .shut_req(shut_req),
    .tune_present(tune_present), .bead_tune(bead_tune), .port1_func(port1_func),
    .pen_level(pen_level), .ovc_pin_sel(ovc_pin_sel), .ovc_active_high(ovc_active_high),
    .phy_status(phy_status), .init_ack(init_ack), .shut_ack(shut_ack), .busy(busy),
    .done(done), .error(error), .underflow(underflow), .use_count(use_count),
    .reg_wr(reg_wr), .reg_bank(reg_bank), .reg_addr(reg_addr), .reg_wdata(reg_wdata));

  logic [40:0] wlog [0:511];
  int wn = 0;
  always @(posedge clk) if (reg_wr) begin
    wlog[wn[8:0]] <= {reg_bank, reg_addr, reg_wdata};
    wn <= wn + 1;
  end

  int nchk = 0, nerr = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_init(output int cyc);
    @(negedge clk); init_req = 1; #1;
    while (!init_ack) begin @(negedge clk); #1; end
    @(negedge clk); init_req = 0; cyc = 1;
    while (!done && cyc < 30000) begin @(negedge clk); cyc++; end
  endtask

  task automatic do_shut();
    @(negedge clk); shut_req = 1; #1;
    while (!shut_ack) begin @(negedge clk); #1; end
    @(negedge clk); shut_req = 0;
    while (busy) @(negedge clk);
  endtask

  // {tune_present, bead, port1_func, pen, sel[2:0], high[2:0], expected port word}
  localparam logic [25:0] VEC [7] = '{
    {1'b1, 1'b1, 1'b0, 1'b0, 3'b000, 3'b000, 16'h0000},
    {1'b1, 1'b0, 1'b1, 1'b1, 3'b000, 3'b000, 16'h0011},
    {1'b0, 1'b0, 1'b0, 1'b0, 3'b111, 3'b000, 16'h0700},
    {1'b1, 1'b1, 1'b0, 1'b0, 3'b000, 3'b001, 16'h0008},
    {1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 3'b010, 16'h0002},
    {1'b1, 1'b0, 1'b0, 1'b0, 3'b000, 3'b100, 16'h0040},
    {1'b1, 1'b0, 1'b1, 1'b1, 3'b101, 3'b111, 16'h055B}
  };

  initial begin
    repeat (150000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int cyc, base;
    logic [40:0] ex [0:7];
    int ne;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 count", use_count, 0);
    chk("R1 flags", {done, error, underflow}, 0);
    chk("R1 writes", wn, 0);
    chk("R1 acks", {init_ack, shut_ack}, 0);

    // R11 shutdown at zero count
    do_shut();
    @(negedge clk);
    chk("R11 underflow", underflow, 1);
    chk("R11 count", use_count, 0);
    chk("R11 writes", wn, 0);

    // R3 R4 R7 R8 table walk
    for (int v = 0; v < 7; v++) begin
      {tune_present, bead_tune, port1_func, pen_level, ovc_pin_sel, ovc_active_high} = VEC[v][25:16];
      base = wn;
      do_init(cyc);
      ne = 0;
      ex[ne++] = {1'b0, 8'h04, 32'h1};
      ex[ne++] = {1'b0, 8'h04, 32'h3};
      if (VEC[v][25]) begin
        ex[ne++] = {1'b1, 8'h24, VEC[v][24] ? 32'h41 : 32'h00};
        ex[ne++] = {1'b1, 8'h28, VEC[v][24] ? 32'h0D : 32'h07};
      end
      ex[ne++] = {1'b0, 8'h04, 32'h7};
      ex[ne++] = {1'b0, 8'h00, 16'h0, VEC[v][15:0]};
      ex[ne++] = {1'b0, 8'h0C, 32'h0};
      ex[ne++] = {1'b0, 8'h1C, 32'h0};
      chk("R3 done seen", done, 1);
      chk("R6 no error", error, 0);
      chk("R4 write count", wn - base, ne);
      for (int k = 0; k < ne; k++)
        chk($sformatf("R7 R8 R3 vec%0d write%0d", v, k), wlog[base + k], ex[k]);
      @(negedge clk);
      chk("R12 done pulse", done, 0);
      base = wn;
      do_shut();
      chk("R10 off write count", wn - base, 1);
      chk("R10 off write", wlog[base], {1'b0, 8'h04, 32'h0});
      chk("R10 count", use_count, 0);
    end
    chk("R11 sticky", underflow, 1);

    // R9 R10 use count
    tune_present = 0;
    do_init(cyc);
    base = wn;
    do_init(cyc);
    chk("R9 second init done", done, 1);
    chk("R9 second init no writes", wn - base, 0);
    chk("R9 count two", use_count, 2);
    do_shut();
    chk("R10 middle shut no write", wn - base, 0);
    chk("R10 count one", use_count, 1);
    do_shut();
    chk("R10 last shut write", wlog[base], {1'b0, 8'h04, 32'h0});
    chk("R10 count zero", use_count, 0);

    // R2 init priority and held shutdown
    phy_status = 32'h0;
    @(negedge clk); init_req = 1; shut_req = 1; #1;
    chk("R2 init priority", {init_ack, shut_ack}, 2'b10);
    @(negedge clk); init_req = 0; #1;
    chk("R2 busy", busy, 1);
    chk("R2 shut held", shut_ack, 0);
    repeat (60) @(negedge clk);
    #1;
    chk("R5 still polling", {busy, shut_ack}, 2'b10);
    base = wn;
    phy_status = 32'hC000_0000;
    cyc = 0;
    while (!done && cyc < 200) begin @(negedge clk); cyc++; end
    chk("R5 late ready no error", error, 0);
    chk("R5 late ready writes", wn - base, 4);
    #1;
    chk("R2 shut taken after idle", shut_ack, 1);
    @(negedge clk); shut_req = 0;
    while (busy) @(negedge clk);
    chk("R2 count after held shut", use_count, 0);

    // R6 timeout with a stray status bit
    phy_status = 32'hC000_0001;
    base = wn;
    do_init(cyc);
    chk("R6 error", error, 1);
    chk("R6 only two writes", wn - base, 2);
    chk("R6 poll budget", cyc >= POLLS * (WAITC + 1), 1);
    chk("R6 count", use_count, 1);
    do_shut();
    chk("R6 off after error", wlog[base + 2], {1'b0, 8'h04, 32'h0});

    // R12 error cleared by next power-up
    phy_status = 32'hC000_0000;
    do_init(cyc);
    chk("R12 error cleared", error, 0);
    do_shut();

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule